// File: doc/BRIEF.md
# Byte-Wide SPI Master with Completion Flag

This block is a serial master that moves one byte per transfer. The host writes a byte into the transmit port while the block is idle. That write alone starts an internal serial clock. The block then shifts the byte out on MOSI, most significant bit first, and collects the same number of bits from MISO. After the eighth bit the serial clock stops by itself. A completion flag is raised, and an interrupt line follows it if the host has enabled interrupts.

The slave-select line is never driven by the transfer logic. It is a plain output bit that the host sets or clears through its own write strobe. Packets of several bytes are formed by keeping select low and writing byte after byte. Raising select ends the packet.

The transmit side has no queue. A byte written while a transfer is running is dropped, and a collision bit is set instead. The received byte is copied into a holding buffer when the transfer ends. The next transfer's byte overwrites it if the host has not fetched it by then. The completion flag clears in one of two ways: a status read made while the flag is up, followed by any data-port access, or an explicit clear strobe.

Top module: `spi_byte_master`

## Requirements
- R1: A transmit write while idle asserts `busy` on the next clock. `busy` falls exactly 16·H clocks after that edge, where H is `half_div`; a `half_div` of 0 acts as 1. Exactly 8 rising SCK edges occur in the transfer.
- R2: SCK idles low whenever no transfer runs. During a transfer each SCK phase lasts H clocks, so the SCK period is 2·H clocks.
- R3: Bits travel MSB first in mode 0. MOSI presents a bit before the SCK rising edge and changes only after a falling edge. MISO is sampled on the rising edge. The slave therefore receives the written byte, and the master receives the slave's byte.
- R4: `done_flag` becomes 1 on the same clock edge on which `busy` falls.
- R5: `irq` is 1 exactly when `done_flag` is 1 and `irq_en` is 1.
- R6: `ss_n` is 1 after reset. It takes the value of `sel_wr_val` only on a clock where `sel_wr_en` is 1. A transfer never changes it.
- R7: A transmit write while `busy` is 1 does not disturb the running transfer. It sets `wcol_flag` on the next clock.
- R8: `rx_byte` holds the byte received by the most recent completed transfer. It changes only when a transfer completes, so an unread byte is replaced by the next one.
- R9: A status read (`stat_rd_en`) made while a flag is up, followed later by a data access (`rx_rd_en` or `tx_wr_en`), clears `done_flag` and `wcol_flag`. A data access without a prior status read, or a status read alone, leaves them set.
- R10: A `flag_clr` pulse clears `done_flag` and `wcol_flag` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | SCK half-period in clocks (0 treated as 1) |
| irq_en | input | 1 | Interrupt enable |
| sel_wr_en | input | 1 | Strobe that loads the select bit |
| sel_wr_val | input | 1 | Value loaded into the select output |
| tx_wr_en | input | 1 | Transmit data write strobe |
| tx_byte | input | W | Byte to transmit |
| rx_rd_en | input | 1 | Receive data read strobe |
| stat_rd_en | input | 1 | Status read strobe |
| flag_clr | input | 1 | Explicit flag clear pulse |
| miso | input | 1 | Serial data from the slave |
| rx_byte | output | W | Receive holding buffer |
| done_flag | output | 1 | Transfer complete flag |
| wcol_flag | output | 1 | Write collision flag |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Host-controlled slave select |

## Verification
The bench builds the block with an 8-bit word and a 4-bit divider field. With that width, transfers at half-periods 0, 1, 2 and 3 can be timed cycle by exactly against 16·H, including the zero-means-one case. A behavioural slave in the bench shifts its own byte back, so both directions of the ring are compared against known patterns. The short transfers leave room to test collisions in the middle of a transfer, back-to-back overwrite of the receive buffer, and both flag-clearing paths.

// File: rtl/spi_pkg.sv
package spi_pkg;
  // Flag state held by the completion logic
  typedef struct packed {
    logic flag;   // transfer complete
    logic wcol;   // write arrived while busy
    logic seen;   // status was read while a flag was up
  } spi_flag_s;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half_eff;
  logic             at_end;

  assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign at_end   = (cnt_q == half_eff - DIV_W'(1));
  assign tick     = run && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         tick,
  input  logic         miso,
  output logic         busy,
  output logic         sck,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             busy_q, busy_d;
  logic             sck_q, sck_d;
  logic             samp_q, samp_d;
  logic             last_bit;

  assign last_bit = (bit_q == CNT_W'(W - 1));
  assign done     = tick && sck_q && last_bit;
  assign rx_word  = {sh_q[W-2:0], samp_q};
  assign busy     = busy_q;
  assign sck      = sck_q;
  assign mosi     = sh_q[W-1];

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    sck_d  = sck_q;
    samp_d = samp_q;
    if (!busy_q) begin
      if (load) begin
        sh_d   = load_data;
        bit_d  = '0;
        busy_d = 1'b1;
        sck_d  = 1'b0;
      end
    end else if (tick) begin
      if (!sck_q) begin
        sck_d  = 1'b1;
        samp_d = miso;
      end else begin
        sck_d = 1'b0;
        sh_d  = {sh_q[W-2:0], samp_q};
        bit_d = bit_q + CNT_W'(1);
        if (last_bit) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
      sck_q  <= sck_d;
      samp_q <= samp_d;
    end
  end
endmodule

// File: rtl/spi_flags.sv
module spi_flags
  import spi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic collide,
  input  logic data_acc,
  input  logic stat_rd,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic wcol,
  output logic irq
);
  spi_flag_s st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (stat_rd && (st_q.flag || st_q.wcol)) st_d.seen = 1'b1;
    if ((st_q.seen && data_acc) || clr) begin
      st_d.flag = 1'b0;
      st_d.wcol = 1'b0;
      st_d.seen = 1'b0;
    end
    if (done)    st_d.flag = 1'b1;
    if (collide) st_d.wcol = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign flag = st_q.flag;
  assign wcol = st_q.wcol;
  assign irq  = st_q.flag && irq_en;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             irq_en,
  input  logic             sel_wr_en,
  input  logic             sel_wr_val,
  input  logic             tx_wr_en,
  input  logic [W-1:0]     tx_byte,
  input  logic             rx_rd_en,
  input  logic             stat_rd_en,
  input  logic             flag_clr,
  input  logic             miso,
  output logic [W-1:0]     rx_byte,
  output logic             done_flag,
  output logic             wcol_flag,
  output logic             busy,
  output logic             irq,
  output logic             sck,
  output logic             mosi,
  output logic             ss_n
);
  logic         tick, done, collide, data_acc;
  logic [W-1:0] rx_word;
  logic [W-1:0] rxbuf_q, rxbuf_d;
  logic         sel_q, sel_d;

  assign collide  = tx_wr_en && busy;
  assign data_acc = tx_wr_en || rx_rd_en;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(half_div), .tick(tick)
  );

  spi_shifter #(.W(W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(tx_wr_en), .load_data(tx_byte),
    .tick(tick), .miso(miso), .busy(busy), .sck(sck), .mosi(mosi),
    .done(done), .rx_word(rx_word)
  );

  spi_flags u_flg (
    .clk(clk), .rst_n(rst_n), .done(done), .collide(collide),
    .data_acc(data_acc), .stat_rd(stat_rd_en), .clr(flag_clr),
    .irq_en(irq_en), .flag(done_flag), .wcol(wcol_flag), .irq(irq)
  );

  always_comb begin
    rxbuf_d = rxbuf_q;
    sel_d   = sel_q;
    if (done)      rxbuf_d = rx_word;
    if (sel_wr_en) sel_d   = sel_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf_q <= '0;
      sel_q   <= 1'b1;
    end else begin
      rxbuf_q <= rxbuf_d;
      sel_q   <= sel_d;
    end
  end

  assign rx_byte = rxbuf_q;
  assign ss_n    = sel_q;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] half_div,
  input logic             irq_en,
  input logic             sel_wr_en,
  input logic             sel_wr_val,
  input logic             tx_wr_en,
  input logic [W-1:0]     tx_byte,
  input logic             rx_rd_en,
  input logic             stat_rd_en,
  input logic             flag_clr,
  input logic             miso,
  input logic [W-1:0]     rx_byte,
  input logic             done_flag,
  input logic             wcol_flag,
  input logic             busy,
  input logic             irq,
  input logic             sck,
  input logic             mosi,
  input logic             ss_n
);
  // R2: serial clock low whenever idle
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R3: MOSI held while SCK stays high
  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sck) && sck) |-> $stable(mosi));

  // R4: flag raised when transfer ends
  a_r4_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  // R5: enabled flag requests interrupt
  a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && irq_en) |-> irq);

  // R6: select moves only on host write
  a_r6_sel_host_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr_en |=> $stable(ss_n));

  // R7: write during transfer marks collision
  a_r7_wcol_on_busy_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_wr_en) |=> wcol_flag);

  // R8: receive buffer updates only at completion
  a_r8_rx_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $fell(busy));

  // R9 / R10: flag drops only through a clear path
  a_r9_flag_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> ($past(flag_clr) || $past(rx_rd_en) || $past(tx_wr_en)));
endmodule

bind spi_byte_master spi_byte_master_chk #(.W(W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
  localparam int W = 8;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [DIV_W-1:0] half_div;
  logic irq_en, sel_wr_en, sel_wr_val, tx_wr_en, rx_rd_en, stat_rd_en, flag_clr;
  logic [W-1:0] tx_byte;
  logic miso;
  logic [W-1:0] rx_byte;
  logic done_flag, wcol_flag, busy, irq, sck, mosi, ss_n;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // behavioural slave
  logic [W-1:0] sl_out, sl_in;
  int sl_bit = 0;
  int rises = 0;
  int rise_t1 = 0, rise_t2 = 0;

  always #10 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  assign miso = (sl_bit < W) ? sl_out[W-1-sl_bit] : 1'b0;
  always @(posedge sck) begin
    sl_in = {sl_in[W-2:0], mosi};
    if (rises == 0) rise_t1 = cyc;
    else if (rises == 1) rise_t2 = cyc;
    rises = rises + 1;
  end
  always @(negedge sck) sl_bit = sl_bit + 1;

  spi_byte_master #(.W(W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .irq_en(irq_en),
    .sel_wr_en(sel_wr_en), .sel_wr_val(sel_wr_val), .tx_wr_en(tx_wr_en),
    .tx_byte(tx_byte), .rx_rd_en(rx_rd_en), .stat_rd_en(stat_rd_en),
    .flag_clr(flag_clr), .miso(miso), .rx_byte(rx_byte),
    .done_flag(done_flag), .wcol_flag(wcol_flag), .busy(busy), .irq(irq),
    .sck(sck), .mosi(mosi), .ss_n(ss_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic slave_prep(input logic [W-1:0] b);
    sl_out = b; sl_in = '0; sl_bit = 0; rises = 0;
  endtask

  // write a byte; returns after the capturing edge (+1 ns)
  task automatic wr_byte(input logic [W-1:0] b);
    @(negedge clk); tx_byte = b; tx_wr_en = 1'b1;
    @(posedge clk); #1; tx_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(sck == 0, "R2 reset sck", sck, 0);
    chk(done_flag == 0 && wcol_flag == 0, "R4 reset flags", {done_flag, wcol_flag}, 0);
    chk(irq == 0, "R5 reset irq", irq, 0);
    chk(ss_n == 1, "R6 reset ss_n", ss_n, 1);
    chk(rx_byte == 0, "R8 reset rx", rx_byte, 0);
  endtask

  task automatic t_xfer(input logic [W-1:0] tx, input logic [W-1:0] sl, input int h);
    int he;
    he = (h == 0) ? 1 : h;
    half_div = DIV_W'(h);
    slave_prep(sl);
    wr_byte(tx);
    chk(busy == 1, "R1 busy rises", busy, 1);
    step(16 * he - 1);
    chk(busy == 1, "R1 busy before end", busy, 1);
    chk(ss_n == 0, "R6 ss_n held by host", ss_n, 0);
    step(1);
    chk(busy == 0, "R1 busy falls at 16H", busy, 0);
    chk(rises == 8, "R1 eight rising edges", rises, 8);
    chk(sck == 0, "R2 sck low after", sck, 0);
    chk(sl_in == tx, "R3 slave receives byte", sl_in, tx);
    chk(rx_byte == sl, "R3 master receives byte", rx_byte, sl);
    chk(done_flag == 1, "R4 flag set", done_flag, 1);
  endtask

  task automatic t_select();
    @(negedge clk) begin sel_wr_en = 1'b1; sel_wr_val = 1'b0; end
    @(negedge clk) sel_wr_en = 1'b0;
    chk(ss_n == 0, "R6 host drives select low", ss_n, 0);
  endtask

  task automatic t_period();
    t_xfer(8'h3C, 8'h81, 3);
    chk(rise_t2 - rise_t1 == 6, "R2 period 2H", rise_t2 - rise_t1, 6);
    pulse_clr();
    chk(done_flag == 0, "R10 clear pulse", done_flag, 0);
  endtask

  task automatic t_irq();
    irq_en = 1'b0;
    t_xfer(8'hA5, 8'h5A, 1);
    chk(irq == 0, "R5 irq masked", irq, 0);
    @(negedge clk) irq_en = 1'b1; #1;
    chk(irq == 1, "R5 irq enabled", irq, 1);
    pulse_clr();
    chk(irq == 0, "R5 irq drops with flag", irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_collision();
    half_div = DIV_W'(2);
    slave_prep(8'hC3);
    wr_byte(8'h96);
    step(5);
    @(negedge clk); tx_byte = 8'h0F; tx_wr_en = 1'b1;
    @(negedge clk); tx_wr_en = 1'b0;
    chk(wcol_flag == 1, "R7 collision bit", wcol_flag, 1);
    while (busy) @(negedge clk);
    chk(sl_in == 8'h96, "R7 running byte kept", sl_in, 8'h96);
    chk(rx_byte == 8'hC3, "R7 rx intact", rx_byte, 8'hC3);
    pulse_clr();
    chk(wcol_flag == 0 && done_flag == 0, "R10 clears both", {wcol_flag, done_flag}, 0);
  endtask

  task automatic t_overrun();
    t_xfer(8'h11, 8'h22, 1);
    step(3);
    chk(rx_byte == 8'h22, "R8 rx held idle", rx_byte, 8'h22);
    t_xfer(8'h33, 8'h44, 1);
    chk(rx_byte == 8'h44, "R8 unread byte replaced", rx_byte, 8'h44);
    pulse_clr();
  endtask

  task automatic t_clear_seq();
    t_xfer(8'h7E, 8'hE7, 2);
    @(negedge clk) rx_rd_en = 1'b1;
    @(negedge clk) rx_rd_en = 1'b0;
    chk(done_flag == 1, "R9 data read alone keeps flag", done_flag, 1);
    @(negedge clk) stat_rd_en = 1'b1;
    @(negedge clk) stat_rd_en = 1'b0;
    chk(done_flag == 1, "R9 status read alone keeps flag", done_flag, 1);
    @(negedge clk) rx_rd_en = 1'b1;
    @(negedge clk) rx_rd_en = 1'b0;
    chk(done_flag == 0, "R9 status then data clears", done_flag, 0);
    chk(rx_byte == 8'hE7, "R8 read leaves buffer", rx_byte, 8'hE7);
  endtask

  task automatic t_deselect();
    @(negedge clk) begin sel_wr_en = 1'b1; sel_wr_val = 1'b1; end
    @(negedge clk) sel_wr_en = 1'b0;
    chk(ss_n == 1, "R6 host raises select", ss_n, 1);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; half_div = '0; irq_en = 1'b0; sel_wr_en = 1'b0; sel_wr_val = 1'b1;
    tx_wr_en = 1'b0; tx_byte = '0; rx_rd_en = 1'b0; stat_rd_en = 1'b0; flag_clr = 1'b0;
    sl_out = '0; sl_in = '0;
    step(3);
    #5 rst_n = 1'b1;
    step(2);
    t_reset();
    t_select();
    t_xfer(8'hB4, 8'h69, 0);   // R1: zero divisor acts as one
    pulse_clr();
    t_period();
    t_irq();
    t_collision();
    t_overrun();
    t_clear_seq();
    t_deselect();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule